// File: doc/BRIEF.md
# Interrupt Router with Claim and Complete

The block gathers level-high or rising-edge interrupt requests from NSRC sources and routes them to NCTX target contexts. The sources are numbered 1 to NSRC; number 0 means "none". Each source has a programmable priority, and each context has its own enable vector and threshold. A context's interrupt line is high when at least one source is pending, is enabled for that context, and has a priority strictly above the context's threshold.

Software services an interrupt in two steps. It reads the context's claim register, which returns the winning source number and removes that source from the pending set. It then writes the same number back to the same register to complete it. Between the claim and the completion the source cannot become pending again. A per-source gateway holds the request and the in-flight state, and applies the trigger mode that a static strap input selects.

All state is reached over a simple 32-bit register bus. A read returns data on `bus_rdata` one cycle later, marked by `bus_rvalid`. A write takes effect at the clock edge where it is presented.

Top module: `irq_router`

## Requirements
- R1: The priority of source i (1..NSRC) sits at byte address i*4 and reads back the low PRIO_W bits of the value written. Address 0 reads 0, and writes to it are ignored.
- R2: The enable bit of source i for context c is bit i%32 of the word at 0x2000 + c*0x80 + (i/32)*4. Bit 0 of word 0 and bits above NSRC always read 0.
- R3: `irq_out[c]` is high exactly when some source is pending, enabled for c, and has a priority strictly greater than the threshold of c. Priority 0 never interrupts, and a threshold of all ones masks every source.
- R4: A read of the claim register (0x200004 + c*0x1000) returns the eligible source of highest priority for c. When priorities tie, the lowest number wins. The read returns 0 when no source is eligible.
- R5: A claim clears the pending bit of the returned source. The source then stays non-pending until it is completed, even while its input stays high.
- R6: Writing a source number to a context's claim register completes that source and lets it request again. The write is ignored when the source's enable bit for that context is clear.
- R7: In level mode (`src_edge` bit 0) the gateway sets pending whenever the input is high and no request is in flight. Pending stays latched if the input falls before the claim.
- R8: In edge mode (`src_edge` bit 1) a rising edge sets pending, and holding the input high gives no further request. A rising edge that arrives between claim and completion is kept, and it becomes pending at completion.
- R9: The pending bits are readable at 0x1000 + (i/32)*4, with source i at bit i%32. Writes to these addresses have no effect.
- R10: Reads of unimplemented or unaligned addresses return 0, and writes to them change nothing.
- R11: The threshold of context c sits at 0x200000 + c*0x1000 and reads back the low PRIO_W bits of the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| src_irq | input | NSRC | Request inputs; bit i-1 is source i |
| src_edge | input | NSRC | Trigger mode strap; bit i-1 is source i (1 = edge) |
| irq_out | output | NCTX | Interrupt line per context |

## Verification
The hardest state to reach is an edge-mode source that receives a new rising edge while it is claimed but not yet completed. The pending set must stay clean until the completion write, and the request must then reappear. The bench claims the edge source, pulses it again, and reads the pending vector both before and after the completion. Refused completions are also hard to observe. The bench clears one enable bit, completes a source that is still held high, and checks that the pending bit does not return until the enable is set and the completion is repeated.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned PEND_BASE  = 32'h0000_1000;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned THR_OFS    = 32'h0;
  localparam int unsigned CLAIM_OFS  = 32'h4;

  // 32-bit words needed to hold bits 0..nsrc
  function automatic int unsigned vec_words(int unsigned nsrc);
    return (nsrc + 1 + 31) / 32;
  endfunction
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic edge_mode,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic busy_o
);
  logic in_q, pend_q, busy_q, saved_q;
  logic in_d, pend_d, busy_d, saved_d;
  logic rise, inflight, fire, done;

  always_comb begin
    rise     = irq_in & ~in_q;
    inflight = pend_q | busy_q;
    fire     = edge_mode ? rise : irq_in;
    done     = complete_i & busy_q;
    in_d     = irq_in;
    pend_d   = pend_q;
    busy_d   = busy_q;
    saved_d  = saved_q;
    if (claim_i && pend_q) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else if (done) begin
      busy_d  = 1'b0;
      saved_d = 1'b0;
      pend_d  = edge_mode ? (saved_q | rise) : irq_in;
    end else if (!inflight) begin
      pend_d = fire;
    end else if (edge_mode && busy_q && rise) begin
      saved_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      saved_q <= 1'b0;
    end else begin
      in_q    <= in_d;
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      saved_q <= saved_d;
    end
  end

  assign pending_o = pend_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 6
) (
  input  logic [NSRC:1]             pending,
  input  logic [NSRC:1]             enable,
  input  logic [NSRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           win_id,
  output logic                      irq
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best   = '0;
    win_id = '0;
    irq    = 1'b0;
    // ascending scan with strict compare: lowest number wins a tie
    for (int i = 1; i <= int'(NSRC); i++) begin
      if (pending[i] && enable[i] && (prio[i] > thr) && (prio[i] > best)) begin
        best   = prio[i];
        win_id = ID_W'(i);
        irq    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NCTX   = 2,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   src_irq,
  input  logic [NSRC-1:0]   src_edge,
  output logic [NCTX-1:0]   irq_out
);
  localparam int unsigned ID_W  = $clog2(NSRC + 1);
  localparam int unsigned NWORD = vec_words(NSRC);
  localparam int unsigned VW    = NWORD * 32;

  function automatic logic [VW-1:0] make_en_mask();
    logic [VW-1:0] m;
    for (int i = 0; i < int'(VW); i++) m[i] = (i >= 1) && (i <= int'(NSRC));
    return m;
  endfunction
  localparam logic [VW-1:0] EN_MASK = make_en_mask();

  logic [NSRC:1][PRIO_W-1:0] prio_q, prio_d;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic [NCTX-1:0][VW-1:0] en_q, en_d;
  logic [31:0] rdata_q, rdata_d;
  logic rvalid_q;

  logic [NSRC:1] pend_all, busy_all, claim_vec, cmpl_vec;
  logic [VW-1:0] pend_vec;
  logic [NCTX-1:0][ID_W-1:0] win_id;
  logic [NCTX-1:0] ctx_irq;
  logic [31:0] a;
  logic rd, wr;

  // gateways, one per source
  for (genvar i = 1; i <= int'(NSRC); i++) begin : g_gw
    irq_gateway u_gw (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (src_irq[i-1]),
      .edge_mode  (src_edge[i-1]),
      .claim_i    (claim_vec[i]),
      .complete_i (cmpl_vec[i]),
      .pending_o  (pend_all[i]),
      .busy_o     (busy_all[i])
    );
  end

  // arbiters, one per context
  for (genvar c = 0; c < int'(NCTX); c++) begin : g_ctx
    irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
      .pending (pend_all),
      .enable  (en_q[c][NSRC:1]),
      .prio    (prio_q),
      .thr     (thr_q[c]),
      .win_id  (win_id[c]),
      .irq     (ctx_irq[c])
    );
  end

  always_comb begin
    pend_vec         = '0;
    pend_vec[NSRC:1] = pend_all;
  end

  // address decode and next state
  always_comb begin
    a         = 32'(bus_addr);
    rd        = bus_sel & ~bus_we;
    wr        = bus_sel & bus_we;
    rdata_d   = '0;
    prio_d    = prio_q;
    thr_d     = thr_q;
    en_d      = en_q;
    claim_vec = '0;
    cmpl_vec  = '0;

    for (int i = 1; i <= int'(NSRC); i++) begin
      if (a == 32'(i * 4)) begin
        rdata_d = 32'(prio_q[i]);
        if (wr) prio_d[i] = bus_wdata[PRIO_W-1:0];
      end
    end

    for (int w = 0; w < int'(NWORD); w++) begin
      if (a == 32'(PEND_BASE + w * 4)) rdata_d = pend_vec[w*32 +: 32];
    end

    for (int c = 0; c < int'(NCTX); c++) begin
      for (int w = 0; w < int'(NWORD); w++) begin
        if (a == 32'(EN_BASE + c * EN_STRIDE + w * 4)) begin
          rdata_d = en_q[c][w*32 +: 32];
          if (wr) en_d[c][w*32 +: 32] = bus_wdata & EN_MASK[w*32 +: 32];
        end
      end
      if (a == 32'(CTX_BASE + c * CTX_STRIDE + THR_OFS)) begin
        rdata_d = 32'(thr_q[c]);
        if (wr) thr_d[c] = bus_wdata[PRIO_W-1:0];
      end
      if (a == 32'(CTX_BASE + c * CTX_STRIDE + CLAIM_OFS)) begin
        rdata_d = 32'(win_id[c]);
        for (int i = 1; i <= int'(NSRC); i++) begin
          if (rd && win_id[c] == ID_W'(i)) claim_vec[i] = 1'b1;
          if (wr && bus_wdata == 32'(i) && en_q[c][i]) cmpl_vec[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q   <= '0;
      thr_q    <= '0;
      en_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr) begin
        prio_q <= prio_d;
        thr_q  <= thr_d;
        en_q   <= en_d;
      end
      if (rd) rdata_q <= rdata_d;
      rvalid_q <= rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_out    = ctx_irq;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NCTX   = 2,
  parameter int unsigned PRIO_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NSRC:1]                 pend,
  input logic [NSRC:1]                 busy,
  input logic [NSRC:1]                 claim_vec,
  input logic [NCTX-1:0][PRIO_W-1:0]   thr,
  input logic [NCTX-1:0]               irq_out
);
  AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0); // R5

  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec)); // R4

  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((claim_vec & pend) != '0) |=> (((pend & $past(claim_vec)) == '0)
      && ((busy & $past(claim_vec)) == $past(claim_vec)))); // R5

  for (genvar c = 0; c < int'(NCTX); c++) begin : g_c
    AST_THR_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[c] == '1) |-> !irq_out[c]); // R3
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[c] |-> (pend != '0)); // R3
  end
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend_all),
  .busy      (busy_all),
  .claim_vec (claim_vec),
  .thr       (thr_q),
  .irq_out   (irq_out)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NSRC = 40;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_we;
  logic [21:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_rvalid;
  logic [NSRC-1:0] src_irq, src_edge;
  logic [NCTX-1:0] irq_out;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_irq(src_irq), .src_edge(src_edge),
    .irq_out(irq_out)
  );

  function automatic logic [21:0] a_prio(int id); return 22'(id * 4); endfunction
  function automatic logic [21:0] a_pend(int w); return 22'(32'h1000 + w * 4); endfunction
  function automatic logic [21:0] a_en(int c, int w); return 22'(32'h2000 + c * 32'h80 + w * 4); endfunction
  function automatic logic [21:0] a_thr(int c); return 22'(32'h200000 + c * 32'h1000); endfunction
  function automatic logic [21:0] a_clm(int c); return 22'(32'h200004 + c * 32'h1000); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("unexpected_read", bus_rdata, 32'hdead);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [21:0] ad, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [21:0] ad, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ad;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(int id, logic v);
    @(negedge clk);
    src_irq[id-1] = v;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_irq = '0; src_edge = '0; src_edge[8] = 1'b1; // source 9 edge mode
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R3_reset_irq", 32'(irq_out), 32'h0);
    rd(a_clm(0), 0, "R4_reset_claim_empty");
    rd(a_prio(1), 0, "R1_reset_prio");

    wr(a_prio(5), 3);          rd(a_prio(5), 3, "R1_prio_readback");
    wr(a_prio(5), 32'hff);     rd(a_prio(5), 7, "R1_prio_width");
    wr(a_prio(0), 5);          rd(a_prio(0), 0, "R1_prio_id0");
    wr(a_en(0, 0), 32'hffff_ffff); rd(a_en(0, 0), 32'hffff_fffe, "R2_en_bit0");
    wr(a_en(0, 1), 32'hffff_ffff); rd(a_en(0, 1), 32'h1ff, "R2_en_upper");
    wr(a_en(1, 1), 32'h2);     rd(a_en(1, 1), 32'h2, "R2_en_ctx1");
    wr(a_thr(0), 32'h12);      rd(a_thr(0), 2, "R11_thr_readback");
    wr(a_thr(0), 0);
    rd(32'h3000, 0, "R10_unmapped_read");
    wr(32'h3000, 32'h55);      rd(32'h3000, 0, "R10_unmapped_write");
    rd(a_pend(2), 0, "R10_past_pending");
    rd(a_en(2, 0), 0, "R10_no_ctx2");
    rd(a_thr(0) + 8, 0, "R10_ctx_gap");
    rd(a_prio(5) + 1, 0, "R10_unaligned");

    wr(a_prio(3), 2); wr(a_prio(7), 5); wr(a_prio(9), 5); wr(a_prio(33), 5);

    // priority 0 source pends but never interrupts
    set_src(4, 1); idle(3);
    rd(a_pend(0), 32'h10, "R9_pending_read");
    check("R3_prio0_silent", 32'(irq_out[0]), 0);
    wr(a_pend(0), 0); idle(1);
    rd(a_pend(0), 32'h10, "R9_pending_write_ignored");

    // threshold is strict
    set_src(3, 1); idle(3);
    check("R3_irq_on", 32'(irq_out[0]), 1);
    wr(a_thr(0), 2); idle(1);
    check("R3_thr_equal_masks", 32'(irq_out[0]), 0);
    wr(a_thr(0), 1); idle(1);
    check("R3_thr_below", 32'(irq_out[0]), 1);
    wr(a_thr(0), 7); idle(1);
    check("R3_thr_max", 32'(irq_out[0]), 0);
    wr(a_thr(0), 0); idle(1);
    check("R3_ctx1_not_enabled", 32'(irq_out[1]), 0);

    // tie break and cross-word arbitration
    set_src(7, 1); set_src(33, 1); idle(3);
    check("R3_ctx1_on", 32'(irq_out[1]), 1);
    rd(a_clm(0), 7, "R4_tie_lowest_id");
    rd(a_pend(0), 32'h18, "R5_claim_clears");
    rd(a_clm(0), 33, "R4_second_word");
    idle(1);
    check("R5_ctx1_drops", 32'(irq_out[1]), 0);
    rd(a_clm(0), 3, "R4_lower_prio");
    rd(a_clm(0), 0, "R4_none_left");
    idle(4);
    rd(a_pend(0), 32'h10, "R5_blocked_while_high");
    rd(a_pend(1), 0, "R5_blocked_word1");

    // completion refused when not enabled
    wr(a_en(0, 0), 32'hffff_ff7f);
    wr(a_clm(0), 7); idle(3);
    rd(a_pend(0), 32'h10, "R6_complete_ignored");
    wr(a_en(0, 0), 32'hffff_ffff);
    wr(a_clm(0), 7); idle(3);
    rd(a_pend(0), 32'h90, "R6_R7_complete_repends");
    set_src(7, 0); idle(3);
    rd(a_pend(0), 32'h90, "R7_level_latched");
    rd(a_clm(0), 7, "R7_claim_after_drop");
    wr(a_clm(0), 7); idle(3);
    rd(a_pend(0), 32'h10, "R7_no_repend_low");

    // completion through the other context
    wr(a_clm(1), 33); idle(3);
    rd(a_pend(1), 32'h2, "R6_ctx1_complete");
    set_src(33, 0);
    rd(a_clm(1), 33, "R4_ctx1_claim");
    wr(a_clm(1), 33); idle(3);
    rd(a_pend(1), 0, "R6_ctx1_done");
    set_src(3, 0);
    wr(a_clm(0), 3); idle(3);
    rd(a_pend(0), 32'h10, "R7_src3_done");

    // edge-mode source
    set_src(9, 1); set_src(9, 0); idle(3);
    rd(a_pend(0), 32'h210, "R8_edge_pends");
    rd(a_clm(0), 9, "R8_edge_claim");
    set_src(9, 1); set_src(9, 0); idle(3);
    rd(a_pend(0), 32'h10, "R8_edge_held_while_busy");
    wr(a_clm(0), 9); idle(3);
    rd(a_pend(0), 32'h210, "R8_edge_replayed");
    rd(a_clm(0), 9, "R8_edge_claim2");
    wr(a_clm(0), 9); idle(3);
    rd(a_pend(0), 32'h10, "R8_edge_clean");
    set_src(9, 1); idle(3);
    rd(a_clm(0), 9, "R8_edge_hold_claim");
    wr(a_clm(0), 9); idle(4);
    rd(a_pend(0), 32'h10, "R8_hold_no_repeat");
    set_src(9, 0);

    idle(4);
    check("queue_drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule